// File: doc/BRIEF.md
# Debug Command Decoder

This block sits between a byte-oriented debug link and the rest of a chip's debug logic. Each byte from the host is read as a one-byte command. Some commands carry operand bytes, and the decoder collects those first. The decoder then performs the command:

- it drives a request to the CPU control port (halt, resume, single step, execute an injected instruction, step with a replaced instruction);
- or it forwards three bytes to the breakpoint unit;
- or it starts a mass erase;
- or it answers from its own state.

Answers go back on an outbound byte stream.

The decoder keeps three flags of its own: whether the CPU is halted, whether a mass erase is still running, and whether the last command was refused. Both byte streams use valid/ready. A byte moves on a clock edge where valid and ready are both high. `in_ready` is high only while the decoder waits for a command byte or an operand byte. After the last byte of a command, `in_ready` stays low until the CPU or breakpoint request is acknowledged and every response byte has been taken.

The outbound side may be stalled for any number of cycles. While it is stalled, the pending byte stays on `out_data`. CPU, breakpoint and erase requests are held until their acknowledge arrives, except for the erase start, which is a single-cycle pulse.

Top module: `dbg_cmd_decoder`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and the halted, erase-busy and error flags are all 0.
- R2: Command 0x34 returns one status byte and changes no flag. The status byte has bit 0 = CPU halted, bit 1 = erase busy, bit 2 = last command refused, and bits 7:3 = 0.
- R3: Command 0x44 raises `cpu_req` with `cpu_op` = 1 and holds it until `cpu_ack`. It then sets the halted flag, clears the error flag and returns a status byte.
- R4: The following commands are refused while the CPU is not halted: 0x4C (resume, op 2), 0x5C (step, op 3), 0x55 to 0x57 (execute, op 4) and 0x65 to 0x67 (replace, op 5). A refused command raises no `cpu_req`. It still takes its operand bytes, sets the error flag and returns a status byte with bit 0 = 0.
- R5: For 0x55 to 0x57 and 0x65 to 0x67, the low two opcode bits give the count of operand bytes (1 to 3). The decoder takes that many bytes. `cpu_instr` carries them right-aligned with the first byte most significant, and `cpu_len` equals the count.
- R6: An acknowledged resume clears the halted flag. An acknowledged step, execute or replace leaves it set. Each returns a status byte.
- R7: 0x28 returns `cpu_pc` as two bytes, high byte first. 0x68 returns the PART_ID parameter and then the REV_ID parameter.
- R8: 0x1D followed by one byte stores that byte and returns a status byte. 0x24 returns the stored byte, which is 0 after reset.
- R9: 0x3B followed by three bytes raises `bp_req` with `bp_data` = {first, second, third}. The request is held until `bp_ack`, and no response is sent.
- R10: 0x14 pulses `erase_start` for one cycle, sets the erase-busy flag until `erase_done`, and returns a status byte with bit 1 = 1. While busy, every command byte other than 0x34 is consumed with no response, no request and no flag change.
- R11: An opcode not listed, including 0x54 and 0x64 (operand count 0), causes no request. It sets the error flag and returns a status byte.
- R12: While `out_valid` is 1 and `out_ready` is 0, `out_data` stays unchanged. `in_ready` is never 1 while `out_valid` is 1.
- R13: A one-cycle pulse on `cpu_brk_hit` sets the halted flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Decoder accepts a host byte |
| in_data | input | 8 | Host byte |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Host accepts a response byte |
| out_data | output | 8 | Response byte |
| cpu_req | output | 1 | CPU control request, held until ack |
| cpu_op | output | 3 | 1 halt, 2 resume, 3 step, 4 execute, 5 replace |
| cpu_instr | output | 24 | Injected instruction bytes, right-aligned |
| cpu_len | output | 2 | Number of injected instruction bytes |
| cpu_ack | input | 1 | CPU request done |
| cpu_pc | input | 16 | Current program counter |
| cpu_brk_hit | input | 1 | CPU stopped on a breakpoint |
| bp_req | output | 1 | Breakpoint write request, held until ack |
| bp_data | output | 24 | Breakpoint control and address bytes |
| bp_ack | input | 1 | Breakpoint write done |
| erase_start | output | 1 | One-cycle mass-erase start pulse |
| erase_done | input | 1 | Mass erase finished |

## Verification
The bench builds the decoder with PART_ID = 0xA5 and REV_ID = 0x3C instead of the defaults. This lets the identity response be told apart from a decoder that ignores the parameters or swaps the two bytes. Its CPU and breakpoint models acknowledge after a few cycles, so the held-request path and the response timing after an acknowledge are both exercised. The erase-busy window is kept open under test control, so that a dropped command and an allowed status read can both be observed inside that window.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int BYTE_W    = 8;
  localparam int ARG_BYTES = 3;
  localparam int ARG_W     = ARG_BYTES * BYTE_W;
  localparam int CNT_W     = $clog2(ARG_BYTES + 1);

  typedef enum logic [3:0] {
    K_NONE, K_ERASE, K_WRCFG, K_RDCFG, K_GETPC, K_STATUS, K_BRK,
    K_HALT, K_RESUME, K_STEP, K_EXEC, K_REPL, K_CHIPID
  } cmd_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DATA, S_EXEC, S_CPU, S_BRK, S_RESP
  } state_e;

  typedef struct packed {
    cmd_kind_e        kind;
    logic [CNT_W-1:0] nbytes;
    logic             needs_halt;
  } dec_t;

  function automatic logic [BYTE_W-1:0] pack_status(logic halted, logic busy, logic err);
    pack_status = '0;
    pack_status[0] = halted;
    pack_status[1] = busy;
    pack_status[2] = err;
  endfunction

  function automatic logic [2:0] kind_to_op(cmd_kind_e k);
    case (k)
      K_HALT:   kind_to_op = 3'd1;
      K_RESUME: kind_to_op = 3'd2;
      K_STEP:   kind_to_op = 3'd3;
      K_EXEC:   kind_to_op = 3'd4;
      K_REPL:   kind_to_op = 3'd5;
      default:  kind_to_op = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/dbg_opcode_decode.sv
module dbg_opcode_decode
  import dbg_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output dec_t              dec
);
  always_comb begin
    dec.kind       = K_NONE;
    dec.nbytes     = '0;
    dec.needs_halt = 1'b0;
    casez (opcode)
      8'h14: dec.kind = K_ERASE;
      8'h1D: begin dec.kind = K_WRCFG; dec.nbytes = CNT_W'(1); end
      8'h24: dec.kind = K_RDCFG;
      8'h28: dec.kind = K_GETPC;
      8'h34: dec.kind = K_STATUS;
      8'h3B: begin dec.kind = K_BRK; dec.nbytes = CNT_W'(ARG_BYTES); end
      8'h44: dec.kind = K_HALT;
      8'h4C: begin dec.kind = K_RESUME; dec.needs_halt = 1'b1; end
      8'h5C: begin dec.kind = K_STEP; dec.needs_halt = 1'b1; end
      8'h68: dec.kind = K_CHIPID;
      8'b0101_01??: if (opcode[1:0] != 2'b00) begin
        dec.kind = K_EXEC; dec.needs_halt = 1'b1; dec.nbytes = CNT_W'(opcode[1:0]);
      end
      8'b0110_01??: if (opcode[1:0] != 2'b00) begin
        dec.kind = K_REPL; dec.needs_halt = 1'b1; dec.nbytes = CNT_W'(opcode[1:0]);
      end
      default: dec.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/dbg_arg_shift.sv
module dbg_arg_shift #(
  parameter int NBYTES = 3,
  parameter int BW     = 8,
  localparam int W     = NBYTES * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic [BW-1:0] din,
  output logic [W-1:0]  dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dout <= '0;
    else if (clr)   dout <= '0;
    else if (shift) dout <= {dout[W-BW-1:0], din};
  end
endmodule

// File: rtl/dbg_resp_tx.sv
module dbg_resp_tx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_two,
  input  logic [BW-1:0] load_hi,
  input  logic [BW-1:0] load_lo,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [BW-1:0] out_data
);
  logic [1:0]    left_q;
  logic [BW-1:0] next_q;

  assign out_valid = (left_q != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= 2'd0;
      out_data <= '0;
      next_q   <= '0;
    end else if (load) begin
      left_q   <= load_two ? 2'd2 : 2'd1;
      out_data <= load_two ? load_hi : load_lo;
      next_q   <= load_lo;
    end else if (out_valid && out_ready) begin
      left_q   <= left_q - 2'd1;
      out_data <= next_q;
    end
  end
endmodule

// File: rtl/dbg_cmd_decoder.sv
module dbg_cmd_decoder
  import dbg_pkg::*;
#(
  parameter logic [7:0] PART_ID = 8'h81,
  parameter logic [7:0] REV_ID  = 8'h04
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BYTE_W-1:0]  in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BYTE_W-1:0]  out_data,
  output logic               cpu_req,
  output logic [2:0]         cpu_op,
  output logic [ARG_W-1:0]   cpu_instr,
  output logic [1:0]         cpu_len,
  input  logic               cpu_ack,
  input  logic [2*BYTE_W-1:0] cpu_pc,
  input  logic               cpu_brk_hit,
  output logic               bp_req,
  output logic [ARG_W-1:0]   bp_data,
  input  logic               bp_ack,
  output logic               erase_start,
  input  logic               erase_done
);
  state_e state_q, state_d;
  dec_t   dec_w, dec_q, dec_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic halted_q, halted_d, busy_q, busy_d, err_q, err_d, erase_q, erase_d;
  logic [BYTE_W-1:0] cfg_q, cfg_d;
  logic accept, arg_clr, arg_shift;
  logic [ARG_W-1:0] arg_w;
  logic rsp_load, rsp_two;
  logic [BYTE_W-1:0] rsp_hi, rsp_lo;

  assign in_ready = (state_q == S_IDLE) || (state_q == S_DATA);
  assign accept   = in_valid && in_ready;

  dbg_opcode_decode u_dec (.opcode(in_data), .dec(dec_w));

  dbg_arg_shift #(.NBYTES(ARG_BYTES), .BW(BYTE_W)) u_arg (
    .clk(clk), .rst_n(rst_n), .clr(arg_clr), .shift(arg_shift),
    .din(in_data), .dout(arg_w)
  );

  dbg_resp_tx #(.BW(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(rsp_load), .load_two(rsp_two),
    .load_hi(rsp_hi), .load_lo(rsp_lo), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data)
  );

  always_comb begin
    state_d = state_q; dec_d = dec_q; remain_d = remain_q;
    halted_d = halted_q; busy_d = busy_q; err_d = err_q; cfg_d = cfg_q;
    erase_d = 1'b0; arg_clr = 1'b0; arg_shift = 1'b0;
    rsp_load = 1'b0; rsp_two = 1'b0; rsp_hi = '0; rsp_lo = '0;
    case (state_q)
      S_IDLE: begin
        if (accept && !(busy_q && dec_w.kind != K_STATUS)) begin
          dec_d   = dec_w;
          arg_clr = 1'b1;
          if (dec_w.nbytes != '0) begin
            remain_d = dec_w.nbytes;
            state_d  = S_DATA;
          end else begin
            state_d = S_EXEC;
          end
        end
      end
      S_DATA: begin
        if (accept) begin
          arg_shift = 1'b1;
          remain_d  = remain_q - CNT_W'(1);
          if (remain_q == CNT_W'(1)) state_d = S_EXEC;
        end
      end
      S_EXEC: begin
        state_d  = S_RESP;
        rsp_load = 1'b1;
        case (dec_q.kind)
          K_STATUS: rsp_lo = pack_status(halted_q, busy_q, err_q);
          K_ERASE: begin
            busy_d = 1'b1; erase_d = 1'b1; err_d = 1'b0;
            rsp_lo = pack_status(halted_q, 1'b1, 1'b0);
          end
          K_WRCFG: begin
            cfg_d = arg_w[BYTE_W-1:0]; err_d = 1'b0;
            rsp_lo = pack_status(halted_q, busy_q, 1'b0);
          end
          K_RDCFG: begin err_d = 1'b0; rsp_lo = cfg_q; end
          K_GETPC: begin
            err_d = 1'b0; rsp_two = 1'b1;
            rsp_hi = cpu_pc[2*BYTE_W-1:BYTE_W]; rsp_lo = cpu_pc[BYTE_W-1:0];
          end
          K_CHIPID: begin
            err_d = 1'b0; rsp_two = 1'b1; rsp_hi = PART_ID; rsp_lo = REV_ID;
          end
          K_BRK: begin err_d = 1'b0; rsp_load = 1'b0; state_d = S_BRK; end
          K_HALT, K_RESUME, K_STEP, K_EXEC, K_REPL: begin
            if (dec_q.needs_halt && !halted_q) begin
              err_d  = 1'b1;
              rsp_lo = pack_status(halted_q, busy_q, 1'b1);
            end else begin
              rsp_load = 1'b0;
              state_d  = S_CPU;
            end
          end
          default: begin
            err_d  = 1'b1;
            rsp_lo = pack_status(halted_q, busy_q, 1'b1);
          end
        endcase
      end
      S_CPU: begin
        if (cpu_ack) begin
          err_d = 1'b0;
          if (dec_q.kind == K_HALT)        halted_d = 1'b1;
          else if (dec_q.kind == K_RESUME) halted_d = 1'b0;
          rsp_load = 1'b1;
          rsp_lo   = pack_status(halted_d, busy_q, 1'b0);
          state_d  = S_RESP;
        end
      end
      S_BRK:  if (bp_ack) state_d = S_IDLE;
      S_RESP: if (!out_valid) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (cpu_brk_hit) halted_d = 1'b1;
    if (erase_done)  busy_d   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      dec_q    <= '0;
      remain_q <= '0;
      halted_q <= 1'b0;
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      cfg_q    <= '0;
      erase_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      dec_q    <= dec_d;
      remain_q <= remain_d;
      halted_q <= halted_d;
      busy_q   <= busy_d;
      err_q    <= err_d;
      cfg_q    <= cfg_d;
      erase_q  <= erase_d;
    end
  end

  assign cpu_req     = (state_q == S_CPU);
  assign cpu_op      = kind_to_op(dec_q.kind);
  assign cpu_instr   = arg_w;
  assign cpu_len     = 2'(dec_q.nbytes);
  assign bp_req      = (state_q == S_BRK);
  assign bp_data     = arg_w;
  assign erase_start = erase_q;
endmodule

// File: rtl/dbg_cmd_decoder_sva.sv
module dbg_cmd_decoder_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       cpu_req,
  input logic [2:0] cpu_op,
  input logic       cpu_ack,
  input logic       bp_req,
  input logic [23:0] bp_data,
  input logic       bp_ack,
  input logic       halted_q,
  input logic       busy_q
);
  assert_halt_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_op != 3'd1) |-> halted_q);

  assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_cpu_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_ack) |=> (cpu_req && $stable(cpu_op)));

  assert_bp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_req && !bp_ack) |=> (bp_req && $stable(bp_data)));

  assert_erase_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (!cpu_req && !bp_req));
endmodule

bind dbg_cmd_decoder dbg_cmd_decoder_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .cpu_req(cpu_req),
  .cpu_op(cpu_op), .cpu_ack(cpu_ack), .bp_req(bp_req), .bp_data(bp_data),
  .bp_ack(bp_ack), .halted_q(halted_q), .busy_q(busy_q)
);

// File: tb/dbg_cmd_decoder_tb.sv
module dbg_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [7:0] out_data;
  logic cpu_req, cpu_ack = 1'b0, cpu_brk_hit = 1'b0;
  logic [2:0] cpu_op;
  logic [23:0] cpu_instr, bp_data;
  logic [1:0] cpu_len;
  logic [15:0] cpu_pc = 16'h0000;
  logic bp_req, bp_ack = 1'b0, erase_start, erase_done = 1'b0;

  int n_chk = 0, n_err = 0, cpu_cnt = 0, bp_cnt = 0, erase_cnt = 0;
  int cpu_wait = 0, bp_wait = 0;
  logic [2:0] last_op = '0;
  logic [23:0] last_instr = '0, last_bp = '0;
  logic [1:0] last_len = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_decoder #(.PART_ID(8'hA5), .REV_ID(8'h3C)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cpu_req(cpu_req), .cpu_op(cpu_op),
    .cpu_instr(cpu_instr), .cpu_len(cpu_len), .cpu_ack(cpu_ack),
    .cpu_pc(cpu_pc), .cpu_brk_hit(cpu_brk_hit), .bp_req(bp_req),
    .bp_data(bp_data), .bp_ack(bp_ack), .erase_start(erase_start),
    .erase_done(erase_done)
  );

  // CPU and breakpoint models: acknowledge a held request after a short delay
  always @(negedge clk) begin
    if (cpu_ack) cpu_ack <= 1'b0;
    else if (rst_n && cpu_req) begin
      if (cpu_wait == 2) begin
        cpu_ack <= 1'b1; cpu_wait <= 0; cpu_cnt <= cpu_cnt + 1;
        last_op <= cpu_op; last_instr <= cpu_instr; last_len <= cpu_len;
      end else cpu_wait <= cpu_wait + 1;
    end
    if (bp_ack) bp_ack <= 1'b0;
    else if (rst_n && bp_req) begin
      if (bp_wait == 3) begin
        bp_ack <= 1'b1; bp_wait <= 0; bp_cnt <= bp_cnt + 1; last_bp <= bp_data;
      end else bp_wait <= bp_wait + 1;
    end
  end

  always @(posedge clk) if (rst_n && erase_start) erase_cnt <= erase_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    int n = 0;
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready && n < 500) begin @(negedge clk); n++; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b);
    int n = 0;
    @(negedge clk);
    out_ready = 1'b1;
    while (!out_valid && n < 500) begin @(negedge clk); n++; end
    b = out_valid ? out_data : 8'hxx;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic cmd_one(input string tag, input logic [7:0] op, input logic [7:0] exp);
    logic [7:0] b;
    send(op);
    recv(b);
    chk(tag, b, exp);
  endtask

  task automatic expect_quiet(input string tag);
    logic seen = 1'b0;
    out_ready = 1'b1;
    repeat (12) begin @(negedge clk); if (out_valid) seen = 1'b1; end
    out_ready = 1'b0;
    chk(tag, seen, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 in_ready after reset", in_ready, 1'b1);
    chk("R1 out_valid after reset", out_valid, 1'b0);
    cmd_one("R1 R2 status after reset", 8'h34, 8'h00);
  endtask

  task automatic t_gate_running;
    int c0 = cpu_cnt;
    cmd_one("R4 resume while running", 8'h4C, 8'h04);
    cmd_one("R2 status read keeps error", 8'h34, 8'h04);
    send(8'h55); send(8'h11);
    begin logic [7:0] b; recv(b); chk("R4 exec while running", b, 8'h04); end
    cmd_one("R4 step while running", 8'h5C, 8'h04);
    chk("R4 no cpu request while running", cpu_cnt, c0);
  endtask

  task automatic t_invalid;
    int c0 = cpu_cnt;
    cmd_one("R11 pc read clears error", 8'h28, 8'h00);
    begin logic [7:0] b; recv(b); end
    cmd_one("R11 len-zero exec opcode", 8'h54, 8'h04);
    cmd_one("R11 len-zero replace opcode", 8'h64, 8'h04);
    cmd_one("R11 unlisted opcode", 8'hFF, 8'h04);
    chk("R11 no cpu request", cpu_cnt, c0);
  endtask

  task automatic t_halt_exec;
    logic [7:0] b;
    cmd_one("R3 halt status", 8'h44, 8'h01);
    chk("R3 halt op", last_op, 3'd1);
    send(8'h56); send(8'hAB); send(8'hCD); recv(b);
    chk("R5 exec status", b, 8'h01);
    chk("R5 exec op", last_op, 3'd4);
    chk("R5 exec instr", last_instr, 24'h00ABCD);
    chk("R5 exec len", last_len, 2'd2);
    send(8'h67); send(8'h01); send(8'h02); send(8'h03); recv(b);
    chk("R5 replace status", b, 8'h01);
    chk("R5 replace op", last_op, 3'd5);
    chk("R5 replace instr", last_instr, 24'h010203);
    chk("R5 replace len", last_len, 2'd3);
    cmd_one("R6 step keeps halted", 8'h5C, 8'h01);
    chk("R6 step op", last_op, 3'd3);
    cmd_one("R6 resume clears halted", 8'h4C, 8'h00);
    chk("R6 resume op", last_op, 3'd2);
  endtask

  task automatic t_pc_id;
    logic [7:0] b;
    cpu_pc = 16'h1234;
    send(8'h28); recv(b); chk("R7 pc high", b, 8'h12); recv(b); chk("R7 pc low", b, 8'h34);
    send(8'h68); recv(b); chk("R7 part id", b, 8'hA5); recv(b); chk("R7 revision", b, 8'h3C);
  endtask

  task automatic t_cfg;
    logic [7:0] b;
    cmd_one("R8 config reset value", 8'h24, 8'h00);
    send(8'h1D); send(8'h5A); recv(b);
    chk("R8 write config status", b, 8'h00);
    cmd_one("R8 config read back", 8'h24, 8'h5A);
  endtask

  task automatic t_brk;
    int c0 = bp_cnt;
    send(8'h3B); send(8'h0C); send(8'h12); send(8'h34);
    expect_quiet("R9 no response to breakpoint");
    chk("R9 breakpoint request", bp_cnt, c0 + 1);
    chk("R9 breakpoint data", last_bp, 24'h0C1234);
  endtask

  task automatic t_erase;
    int c0 = cpu_cnt;
    cmd_one("R10 erase status busy", 8'h14, 8'h02);
    chk("R10 one erase pulse", erase_cnt, 1);
    send(8'h44);
    expect_quiet("R10 halt dropped during erase");
    chk("R10 no cpu request during erase", cpu_cnt, c0);
    cmd_one("R10 status allowed during erase", 8'h34, 8'h02);
    @(negedge clk); erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
    cmd_one("R10 busy cleared", 8'h34, 8'h00);
  endtask

  task automatic t_backpressure;
    logic [7:0] b;
    int n = 0;
    cpu_pc = 16'hBEEF;
    send(8'h28);
    while (!out_valid && n < 100) begin @(negedge clk); n++; end
    repeat (4) begin
      @(negedge clk);
      chk("R12 held valid", out_valid, 1'b1);
      chk("R12 held data", out_data, 8'hBE);
      chk("R12 input blocked", in_ready, 1'b0);
    end
    recv(b); chk("R12 first byte", b, 8'hBE);
    recv(b); chk("R12 second byte", b, 8'hEF);
  endtask

  task automatic t_brk_hit;
    @(negedge clk); cpu_brk_hit = 1'b1; @(negedge clk); cpu_brk_hit = 1'b0;
    cmd_one("R13 breakpoint hit halts", 8'h34, 8'h01);
    cmd_one("R13 resume after hit", 8'h4C, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate_running();
    t_invalid();
    t_halt_exec();
    t_pc_id();
    t_cfg();
    t_brk();
    t_erase();
    t_backpressure();
    t_brk_hit();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule